// File: doc/BRIEF.md
# Link Power Status Monitor

This block sits between the physical-layer core and the link-layer controller. It watches the power-status level that the link drives, sampled on the local system clock, and decides which of three interface modes applies. In **active** mode, control, data and the link request pass straight through. In **reset** mode the link is treated as asleep. The outbound control and data lines are forced to zero and the link request is masked, but the system clock toward the link keeps running. In **disabled** mode the clock enable also drops.

The block measures how long the status level stays low. A single counter restarts on every high sample and saturates at the longer threshold. A stretch at least as long as the short threshold moves the interface to reset mode. A stretch at least as long as the long threshold moves it to disabled mode. When the level is seen high again from either mode, the block passes through a one-cycle initialize step, raising an initialize request, and then releases the gating.

A hardware reset holds the interface in disabled mode. No other input, including the traffic being gated, has any effect on the mode. With the default parameters at a 49.152 MHz clock, the thresholds are 128 and 1280 cycles, which is just over 2.6 µs and 26 µs.

Top module: `link_pwr_watch`

## Requirements
- R1: While `rst_n` is low, `if_mode` reads 2 (disabled), `sysclk_en` is 0, `init_req` is 0, and `ctl_link`, `data_link` and `lreq_core` are all zero.
- R2: After `rst_n` is released with the status input high, `init_req` is high on the third clock edge after release with `if_mode` = 3 (initialize). `if_mode` then reads 0 (active) from the fourth edge on.
- R3: A low stretch shorter than `RST_CYC` consecutive sampled cycles leaves `if_mode` at 0 on every cycle.
- R4: A low stretch of `RST_CYC` or more cycles sets `if_mode` to 1 (reset) on clock edge `RST_CYC`+3, counting the first edge that samples the input low as edge 1.
- R5: Whenever `if_mode` is not 0, `ctl_link` and `data_link` are zero and `lreq_core` is 0. `sysclk_en` is 1 in every mode except mode 2.
- R6: A low stretch of `DIS_CYC` or more cycles sets `if_mode` to 2 on edge `DIS_CYC`+3, and `sysclk_en` is then 0. A low status input after a hardware reset keeps mode 2 until the input goes high.
- R7: On return from mode 1 or 2, `init_req` is high for exactly one cycle, with `if_mode` = 3 and the outputs still gated. It rises on the second or third edge after the first edge that samples the input high, and `if_mode` is 0 on the following cycle.
- R8: The low-time measurement restarts at every high sample and saturates at `DIS_CYC`. Two stretches of `RST_CYC`-1 low cycles separated by one high cycle leave `if_mode` at 0. An arbitrarily long low stretch still recovers within the R7 window.
- R9: In mode 0, `ctl_link`, `data_link` and `lreq_core` equal `ctl_core`, `data_core` and `lreq_link` on the same cycle. Activity on those inputs never changes `if_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock toward the link |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| lps_async | input | 1 | Link power status level, asynchronous to clk |
| ctl_core | input | CTL_W | Control value from the core toward the link |
| data_core | input | DATA_W | Data value from the core toward the link |
| lreq_link | input | 1 | Request line arriving from the link |
| ctl_link | output | CTL_W | Gated control toward the link |
| data_link | output | DATA_W | Gated data toward the link |
| lreq_core | output | 1 | Masked request delivered to the core |
| sysclk_en | output | 1 | Enable for the clock driven to the link |
| if_mode | output | 2 | Mode: 0 active, 1 reset, 2 disabled, 3 initialize |
| init_req | output | 1 | One-cycle request to reinitialize the link interface |

## Verification
The bound checker checks the following on every cycle:
- the zero gating of the outbound lines in all non-active modes;
- the clock enable in reset and disabled modes;
- that active mode is entered only right after a single initialize cycle;
- that reset mode is entered only when the short threshold has been crossed;
- the counter's clear and saturation behaviour.

The exact threshold boundaries can only be shown by the bench's sweep over every low-stretch length up to past the long threshold. The same holds for the entry edges counted through the synchronizer and for the recovery window. Also bench-only are the restart after a one-cycle glitch, recovery from a hardware reset with the status input held low, and the pass-through of random traffic.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    IFM_ACTIVE = 2'd0,
    IFM_RESET  = 2'd1,
    IFM_OFF    = 2'd2,
    IFM_INIT   = 2'd3
  } ifmode_e;

  // outbound lines are gated in every mode but active
  function automatic logic ifm_gated(ifmode_e m);
    return (m != IFM_ACTIVE);
  endfunction

  // the link clock only stops in the disabled mode
  function automatic logic ifm_clk_on(ifmode_e m);
    return (m != IFM_OFF);
  endfunction

  // mode step; threshold hits win over a high sample in the same cycle
  function automatic ifmode_e ifm_next(ifmode_e cur, logic hit_rst, logic hit_off,
                                       logic lvl_high);
    ifmode_e nx;
    case (cur)
      IFM_ACTIVE: begin
        if (hit_off)      nx = IFM_OFF;
        else if (hit_rst) nx = IFM_RESET;
        else              nx = IFM_ACTIVE;
      end
      IFM_RESET: begin
        if (hit_off)       nx = IFM_OFF;
        else if (lvl_high) nx = IFM_INIT;
        else               nx = IFM_RESET;
      end
      IFM_OFF:  nx = lvl_high ? IFM_INIT : IFM_OFF;
      IFM_INIT: nx = IFM_ACTIVE;
      default:  nx = IFM_OFF;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lpm_low_timer.sv
module lpm_low_timer #(
  parameter int RST_CYC = 128,
  parameter int DIS_CYC = 1280,
  parameter int CNT_W   = $clog2(DIS_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_high,
  output logic [CNT_W-1:0] low_cnt,
  output logic             hit_rst,
  output logic             hit_off
);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(DIS_CYC);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RST_CYC);

  // restart on a high sample, otherwise count up to the long threshold
  function automatic logic [CNT_W-1:0] next_low(logic [CNT_W-1:0] cur, logic hi);
    if (hi)            return '0;
    else if (cur >= SAT_V) return SAT_V;
    else               return cur + 1'b1;
  endfunction

  // after reset the stretch counts as already long: the interface starts disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= SAT_V;
    else        low_cnt <= next_low(low_cnt, lvl_high);
  end

  assign hit_rst = (low_cnt >= RST_V);
  assign hit_off = (low_cnt >= SAT_V);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hit_rst,
  input  logic    hit_off,
  input  logic    lvl_high,
  output ifmode_e mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= IFM_OFF;
    else        mode_q <= ifm_next(mode_q, hit_rst, hit_off, lvl_high);
  end
endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
  import lpm_pkg::*;
#(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input  ifmode_e           mode,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              lreq_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              lreq_o,
  output logic              clk_en_o,
  output logic              init_o
);
  logic blk;
  assign blk      = ifm_gated(mode);
  assign ctl_o    = blk ? '0 : ctl_i;
  assign data_o   = blk ? '0 : data_i;
  assign lreq_o   = blk ? 1'b0 : lreq_i;
  assign clk_en_o = ifm_clk_on(mode);
  assign init_o   = (mode == IFM_INIT);
endmodule

// File: rtl/link_pwr_watch.sv
module link_pwr_watch
  import lpm_pkg::*;
#(
  parameter int CTL_W       = 2,
  parameter int DATA_W      = 8,
  parameter int RST_CYC     = 128,
  parameter int DIS_CYC     = 1280,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lps_async,
  input  logic [CTL_W-1:0]  ctl_core,
  input  logic [DATA_W-1:0] data_core,
  input  logic              lreq_link,
  output logic [CTL_W-1:0]  ctl_link,
  output logic [DATA_W-1:0] data_link,
  output logic              lreq_core,
  output logic              sysclk_en,
  output logic [1:0]        if_mode,
  output logic              init_req
);
  localparam int CNT_W = $clog2(DIS_CYC + 1);

  // named internal events, observed by the bound checker
  logic             lps_lvl;
  logic [CNT_W-1:0] low_cnt;
  logic             th_reset_hit;
  logic             th_off_hit;
  ifmode_e          mode_q;

  if (SYNC_STAGES > 0) begin : g_sync
    lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(lps_async), .q_sync(lps_lvl)
    );
  end else begin : g_nosync
    assign lps_lvl = lps_async;
  end

  lpm_low_timer #(.RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .lvl_high(lps_lvl),
    .low_cnt(low_cnt), .hit_rst(th_reset_hit), .hit_off(th_off_hit)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hit_rst(th_reset_hit), .hit_off(th_off_hit),
    .lvl_high(lps_lvl), .mode_q(mode_q)
  );

  lpm_gate #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_gate (
    .mode(mode_q), .ctl_i(ctl_core), .data_i(data_core), .lreq_i(lreq_link),
    .ctl_o(ctl_link), .data_o(data_link), .lreq_o(lreq_core),
    .clk_en_o(sysclk_en), .init_o(init_req)
  );

  assign if_mode = mode_q;
endmodule

// File: rtl/lpm_chk.sv
module lpm_chk #(
  parameter int CTL_W   = 2,
  parameter int DATA_W  = 8,
  parameter int RST_CYC = 128,
  parameter int DIS_CYC = 1280,
  parameter int CNT_W   = $clog2(DIS_CYC + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTL_W-1:0]  ctl_link,
  input logic [DATA_W-1:0] data_link,
  input logic              lreq_core,
  input logic              sysclk_en,
  input logic [1:0]        if_mode,
  input logic              init_req,
  input logic              lps_lvl,
  input logic [CNT_W-1:0]  low_cnt,
  input logic              th_reset_hit,
  input logic              th_off_hit
);
  // R1
  hw_reset_off_chk: assert property (@(posedge clk) !rst_n |=> (if_mode == 2'd2));

  // R5
  gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode != 2'd0) |-> (ctl_link == '0 && data_link == '0 && !lreq_core));

  // R5
  reset_clk_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode == 2'd1) |-> sysclk_en);

  // R6
  off_clk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode == 2'd2) |-> !sysclk_en);

  // R7
  init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> (!init_req && if_mode == 2'd0));

  // R7
  active_via_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode == 2'd0 && $past(if_mode) != 2'd0) |-> $past(init_req));

  // R4
  reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode == 2'd1 && $past(if_mode) == 2'd0) |-> $past(th_reset_hit));

  // R3
  stay_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode == 2'd0 && !th_reset_hit && !th_off_hit) |=> (if_mode == 2'd0));

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= CNT_W'(DIS_CYC));

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lps_lvl |=> (low_cnt == '0));
endmodule

bind link_pwr_watch lpm_chk #(
  .CTL_W(CTL_W), .DATA_W(DATA_W), .RST_CYC(RST_CYC), .DIS_CYC(DIS_CYC), .CNT_W(CNT_W)
) u_lpm_chk (
  .clk(clk), .rst_n(rst_n), .ctl_link(ctl_link), .data_link(data_link),
  .lreq_core(lreq_core), .sysclk_en(sysclk_en), .if_mode(if_mode), .init_req(init_req),
  .lps_lvl(lps_lvl), .low_cnt(low_cnt), .th_reset_hit(th_reset_hit), .th_off_hit(th_off_hit)
);

// File: tb/test_link_pwr_watch.sv
module test_link_pwr_watch;
  localparam int CW = 2;
  localparam int DW = 8;
  localparam int RC = 8;
  localparam int DC = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lps = 1'b1;
  logic [CW-1:0] ctl_c = '0;
  logic [DW-1:0] dat_c = '0;
  logic          lreq_l = 1'b0;
  logic [CW-1:0] ctl_o;
  logic [DW-1:0] dat_o;
  logic          lreq_o;
  logic          clk_en;
  logic [1:0]    mode;
  logic          init_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  link_pwr_watch #(.CTL_W(CW), .DATA_W(DW), .RST_CYC(RC), .DIS_CYC(DC), .SYNC_STAGES(2))
  i_link_pwr_watch (
    .clk(clk), .rst_n(rst_n), .lps_async(lps), .ctl_core(ctl_c), .data_core(dat_c),
    .lreq_link(lreq_l), .ctl_link(ctl_o), .data_link(dat_o), .lreq_core(lreq_o),
    .sysclk_en(clk_en), .if_mode(mode), .init_req(init_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic traffic();
    ctl_c  = CW'($urandom());
    dat_c  = DW'($urandom());
    lreq_l = 1'($urandom());
  endtask

  // counts cycles at the ports that break gating, clock enable or pass-through
  function automatic int port_bad();
    int b = 0;
    if (mode == 2'd0) begin
      if (ctl_o != ctl_c || dat_o != dat_c || lreq_o != lreq_l) b++;
    end else begin
      if (ctl_o != '0 || dat_o != '0 || lreq_o != 1'b0) b++;
    end
    if (clk_en != (mode != 2'd2)) b++;
    return b;
  endfunction

  task automatic run_pulse(int len);
    int first_rst = -1;
    int first_off = -1;
    int n_init = 0;
    int k_init = -1;
    int bad_ports = 0;
    int left_active = 0;
    int after_bad = 0;
    @(negedge clk);
    lps = 1'b0;
    traffic();
    for (int k = 1; k <= len + 8; k++) begin
      @(negedge clk);
      if (mode == 2'd1 && first_rst < 0) first_rst = k;
      if (mode == 2'd2 && first_off < 0) first_off = k;
      if (init_o) begin
        n_init++;
        k_init = k;
        if (mode != 2'd3) after_bad++;
      end
      if (k_init > 0 && k == k_init + 1 && mode != 2'd0) after_bad++;
      if (mode != 2'd0) left_active++;
      bad_ports += port_bad();
      if (k == len) lps = 1'b1;
      traffic();
    end
    if (len < RC) begin
      chk(left_active == 0, $sformatf("R3 len=%0d cycles off active", len), left_active, 0);
    end else begin
      // R4
      chk(first_rst == RC + 3, $sformatf("R4 len=%0d reset entry edge", len), first_rst, RC + 3);
      // R7
      chk(n_init == 1, $sformatf("R7 len=%0d init pulses", len), n_init, 1);
      chk((k_init - (len + 1)) inside {2, 3}, $sformatf("R7 len=%0d init edge after high", len),
          k_init - (len + 1), 2);
      chk(after_bad == 0, $sformatf("R7 len=%0d init/active order", len), after_bad, 0);
    end
    // R6
    chk(first_off == ((len >= DC) ? DC + 3 : -1), $sformatf("R6 len=%0d disable entry edge", len),
        first_off, (len >= DC) ? DC + 3 : -1);
    // R5 and R9
    chk(bad_ports == 0, $sformatf("R5 R9 len=%0d port gating/pass", len), bad_ports, 0);
    chk(mode == 2'd0, $sformatf("R9 len=%0d final mode", len), mode, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int bad;
    int k_init;
    int k_act;
    // R1: reset state under traffic
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      traffic();
      #1;
      if (mode != 2'd2 || clk_en || init_o || ctl_o != '0 || dat_o != '0 || lreq_o) bad++;
    end
    chk(bad == 0, "R1 reset state", bad, 0);

    // R2: release with status high
    @(negedge clk);
    rst_n = 1'b1;
    k_init = -1;
    k_act = -1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (init_o && k_init < 0) k_init = k;
      if (mode == 2'd0 && k_act < 0) k_act = k;
    end
    chk(k_init == 3, "R2 init edge after release", k_init, 3);
    chk(k_act == 4, "R2 active edge after release", k_act, 4);

    // R3 R4 R5 R6 R7 R9: sweep every low-stretch length
    for (int len = 1; len <= DC + 4; len++) begin
      run_pulse(len);
      repeat (3) @(negedge clk);
    end
    // R8: saturated stretch still recovers in the window
    run_pulse(3 * DC);

    // R8: one high sample restarts the measurement
    bad = 0;
    @(negedge clk);
    lps = 1'b0;
    for (int k = 1; k <= 2 * RC + 6; k++) begin
      @(negedge clk);
      if (mode != 2'd0) bad++;
      if (k == RC - 1) lps = 1'b1;
      if (k == RC) lps = 1'b0;
      if (k == 2 * RC - 1) lps = 1'b1;
    end
    chk(bad == 0, "R8 glitch restarts count", bad, 0);

    // R1: hardware reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    traffic();
    #1;
    chk(mode == 2'd2 && !clk_en && ctl_o == '0, "R1 mid-run reset", mode, 2);
    @(negedge clk);
    lps = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R6: low status after reset stays disabled
    bad = 0;
    for (int k = 0; k < DC + 10; k++) begin
      @(negedge clk);
      if (mode != 2'd2 || clk_en) bad++;
    end
    chk(bad == 0, "R6 held disabled while low", bad, 0);
    lps = 1'b1;
    repeat (5) @(negedge clk);
    chk(mode == 2'd0, "R2 recovery after low reset", mode, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule